// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Walker

This block is the control half of a bus-master DMA channel. Software places a table of 8-byte region descriptors in memory and gives the block the table's base address, the number of bytes the device side wants to move, and a direction. After a start pulse the walker fetches descriptors one at a time through a descriptor read port. It then cuts the pending transfer into chunks, each no longer than the bytes left in the current descriptor nor the bytes left on the device side. For each chunk it raises a request carrying an address, a length and a write flag. The actual data movement and bus arbitration sit outside the block, behind a request/acknowledge handshake on each port.

A run ends in one of two ways. If the device byte count reaches zero, the block pulses `done_o`. If the table ends first, it pulses `exhausted_o`. The table ends either on a descriptor carrying the end-of-table flag or once the descriptor pointer has moved a full window (4 KiB by default) past the base. An abort input drops the walker back to idle at once.

The control is one state machine with six states. IDLE waits for a start. EVAL decides the next step. FETCH reads one descriptor. MOVE issues one chunk. FIN pulses done. EXHAUST pulses table-exhausted. Its transitions are as follows:
- start: IDLE to EVAL.
- EVAL to FIN when no device bytes remain.
- EVAL to EXHAUST when the current descriptor is used up and the last flag was seen or the window limit is reached.
- EVAL to FETCH when the current descriptor is used up but the table still has room.
- EVAL to MOVE otherwise.
- FETCH to EVAL and MOVE to EVAL on acknowledge.
- FIN to IDLE and EXHAUST to IDLE unconditionally.
- abort: any state to IDLE.

Top module: `sg_dma_walker`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `exhausted_o`, `dfetch_req_o` and `xfer_req_o` are all low.
- R2: On a start the descriptor pointer is loaded from `tbl_base_i` with its two low bits cleared, and each descriptor fetch advances the pointer by 8 (first fetch at the aligned base, second at base+8).
- R3: A fetched 64-bit word is decoded little-endian. Bits 31:0 are the region address. Bits 47:33 give the byte count, so the count is even and bit 32 is ignored. A count field of zero means 65536 bytes.
- R4: Each chunk request carries the current region address and a length equal to the smaller of the remaining device bytes and the remaining region bytes. After acknowledge, the region address advances by that length. `xfer_we_o` equals the `dir_wr_i` value captured at start.
- R5: A new descriptor is fetched only when the current region has no bytes left. A run whose device bytes end inside a region issues no further fetch.
- R6: Bit 63 of a descriptor marks the end of the table. When the region it describes is used up and device bytes remain, the run ends with a one-cycle `exhausted_o` pulse.
- R7: No descriptor is fetched once the pointer is 4096 (WIN_BYTES) or more bytes past the aligned base, so an unterminated table yields at most 512 fetches and then `exhausted_o`.
- R8: When the device byte count reaches zero the run ends with a one-cycle `done_o` pulse. A start with a device count of zero pulses `done_o` without any request.
- R9: At most one request is outstanding. A raised request keeps its address and length until acknowledged, and the fetch and chunk requests are never high together.
- R10: `abort_i` drops both request outputs in the same cycle. It returns the block to idle (`busy_o` low) on the next cycle, with no done or exhausted pulse.
- R11: A start pulse while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| abort_i | input | 1 | Abort, returns to idle |
| dir_wr_i | input | 1 | Direction: 1 writes host memory, 0 reads it |
| tbl_base_i | input | 32 | Descriptor table base address |
| dev_bytes_i | input | DEV_W | Bytes pending on the device side |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse: device count reached zero |
| exhausted_o | output | 1 | One-cycle pulse: table ended with bytes left |
| dfetch_req_o | output | 1 | Descriptor fetch request |
| dfetch_addr_o | output | 32 | Descriptor address |
| dfetch_ack_i | input | 1 | Fetch acknowledge, data valid |
| dfetch_data_i | input | 64 | Descriptor word (address low, flags high) |
| xfer_req_o | output | 1 | Chunk transfer request |
| xfer_we_o | output | 1 | Chunk direction |
| xfer_addr_o | output | 32 | Chunk host address |
| xfer_len_o | output | 17 | Chunk length in bytes |
| xfer_ack_i | input | 1 | Chunk acknowledge |

## Verification
The hardest condition to reach from the ports is the window stop. It only appears after 512 descriptors in a row carry no end flag. The bench reaches it with a responder that generates descriptor words on the fly from the fetch address, and gives it a device count larger than all 512 regions together. A second hard case is an abort that lands while a request is held pending. The responder has a hold switch that withholds acknowledges, so the bench can assert abort with a fetch request still waiting.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    localparam int SGW_ADDR_W = 32;
    localparam int SGW_LEN_W  = 17;
    localparam int SGW_DESC_W = 64;
    localparam int SGW_DESC_BYTES = 8;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_EVAL    = 3'd1,
        S_FETCH   = 3'd2,
        S_MOVE    = 3'd3,
        S_FIN     = 3'd4,
        S_EXHAUST = 3'd5
    } sgw_state_e;

    typedef struct packed {
        logic [SGW_ADDR_W-1:0] addr;
        logic [SGW_LEN_W-1:0]  len;
        logic                  last;
    } sgw_region_t;

endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode
    import sgw_pkg::*;
(
    input  logic [SGW_DESC_W-1:0] raw_i,
    output sgw_region_t           region_o
);
    logic [14:0] half_count;
    logic        unused_flag_bits;

    assign half_count       = raw_i[47:33];
    assign unused_flag_bits = ^{raw_i[62:48], raw_i[32]};

    always_comb begin
        region_o.addr = raw_i[SGW_ADDR_W-1:0];
        region_o.last = raw_i[63];
        if (half_count == '0) begin
            region_o.len = {1'b1, {(SGW_LEN_W-1){1'b0}}};
        end else begin
            region_o.len = {1'b0, half_count, 1'b0};
        end
    end
endmodule

// File: rtl/sgw_chunk_calc.sv
module sgw_chunk_calc #(
    parameter int DEV_W = 24,
    parameter int LEN_W = 17
) (
    input  logic [DEV_W-1:0] dev_left_i,
    input  logic [LEN_W-1:0] region_left_i,
    output logic [LEN_W-1:0] chunk_o
);
    localparam int PAD_W = DEV_W - LEN_W;

    logic [DEV_W-1:0] region_wide;

    assign region_wide = {{PAD_W{1'b0}}, region_left_i};

    always_comb begin
        if (dev_left_i >= region_wide) begin
            chunk_o = region_left_i;
        end else begin
            chunk_o = dev_left_i[LEN_W-1:0];
        end
    end
endmodule

// File: rtl/sgw_window_check.sv
module sgw_window_check #(
    parameter int ADDR_W    = 32,
    parameter int WIN_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              limit_o
);
    localparam logic [ADDR_W-1:0] WIN_LIM = ADDR_W'(WIN_BYTES);

    logic [ADDR_W-1:0] offset;

    assign offset  = ptr_i - base_i;
    assign limit_o = (offset >= WIN_LIM);
endmodule

// File: rtl/sg_dma_walker.sv
module sg_dma_walker
    import sgw_pkg::*;
#(
    parameter int DEV_W     = 24,
    parameter int WIN_BYTES = 4096
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  abort_i,
    input  logic                  dir_wr_i,
    input  logic [SGW_ADDR_W-1:0] tbl_base_i,
    input  logic [DEV_W-1:0]      dev_bytes_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  exhausted_o,
    output logic                  dfetch_req_o,
    output logic [SGW_ADDR_W-1:0] dfetch_addr_o,
    input  logic                  dfetch_ack_i,
    input  logic [SGW_DESC_W-1:0] dfetch_data_i,
    output logic                  xfer_req_o,
    output logic                  xfer_we_o,
    output logic [SGW_ADDR_W-1:0] xfer_addr_o,
    output logic [SGW_LEN_W-1:0]  xfer_len_o,
    input  logic                  xfer_ack_i
);
    localparam int PAD_W = DEV_W - SGW_LEN_W;
    localparam logic [SGW_ADDR_W-1:0] PTR_STEP = SGW_ADDR_W'(SGW_DESC_BYTES);

    sgw_state_e            state_q, state_d;
    logic [SGW_ADDR_W-1:0] base_q, ptr_q, cur_addr_q;
    logic [SGW_LEN_W-1:0]  cur_len_q;
    logic                  last_q, dir_q;
    logic [DEV_W-1:0]      rem_q;

    sgw_region_t           fetched;
    logic [SGW_LEN_W-1:0]  chunk;
    logic                  win_hit;

    sgw_desc_decode u_decode (
        .raw_i    (dfetch_data_i),
        .region_o (fetched)
    );

    sgw_chunk_calc #(.DEV_W(DEV_W), .LEN_W(SGW_LEN_W)) u_chunk (
        .dev_left_i    (rem_q),
        .region_left_i (cur_len_q),
        .chunk_o       (chunk)
    );

    sgw_window_check #(.ADDR_W(SGW_ADDR_W), .WIN_BYTES(WIN_BYTES)) u_window (
        .ptr_i   (ptr_q),
        .base_i  (base_q),
        .limit_o (win_hit)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) state_d = S_EVAL;
            end
            S_EVAL: begin
                if (rem_q == '0) begin
                    state_d = S_FIN;
                end else if (cur_len_q == '0) begin
                    if (last_q || win_hit) state_d = S_EXHAUST;
                    else                   state_d = S_FETCH;
                end else begin
                    state_d = S_MOVE;
                end
            end
            S_FETCH: begin
                if (dfetch_ack_i) state_d = S_EVAL;
            end
            S_MOVE: begin
                if (xfer_ack_i) state_d = S_EVAL;
            end
            S_FIN:     state_d = S_IDLE;
            S_EXHAUST: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= S_IDLE;
        else if (abort_i) state_q <= S_IDLE;
        else              state_q <= state_d;
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            ptr_q      <= '0;
            cur_addr_q <= '0;
            cur_len_q  <= '0;
            last_q     <= 1'b0;
            dir_q      <= 1'b0;
            rem_q      <= '0;
        end else if (!abort_i) begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        base_q     <= {tbl_base_i[SGW_ADDR_W-1:2], 2'b00};
                        ptr_q      <= {tbl_base_i[SGW_ADDR_W-1:2], 2'b00};
                        rem_q      <= dev_bytes_i;
                        cur_addr_q <= '0;
                        cur_len_q  <= '0;
                        last_q     <= 1'b0;
                        dir_q      <= dir_wr_i;
                    end
                end
                S_FETCH: begin
                    if (dfetch_ack_i) begin
                        ptr_q      <= ptr_q + PTR_STEP;
                        cur_addr_q <= fetched.addr;
                        cur_len_q  <= fetched.len;
                        last_q     <= fetched.last;
                    end
                end
                S_MOVE: begin
                    if (xfer_ack_i) begin
                        cur_addr_q <= cur_addr_q + {{(SGW_ADDR_W-SGW_LEN_W){1'b0}}, chunk};
                        cur_len_q  <= cur_len_q - chunk;
                        rem_q      <= rem_q - {{PAD_W{1'b0}}, chunk};
                    end
                end
                S_EVAL, S_FIN, S_EXHAUST: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o        = (state_q != S_IDLE);
        done_o        = (state_q == S_FIN);
        exhausted_o   = (state_q == S_EXHAUST);
        dfetch_req_o  = (state_q == S_FETCH) && !abort_i;
        dfetch_addr_o = ptr_q;
        xfer_req_o    = (state_q == S_MOVE) && !abort_i;
        xfer_we_o     = dir_q;
        xfer_addr_o   = cur_addr_q;
        xfer_len_o    = chunk;
    end
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        abort_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        exhausted_o,
    input logic        dfetch_req_o,
    input logic [31:0] dfetch_addr_o,
    input logic        dfetch_ack_i,
    input logic        xfer_req_o,
    input logic [31:0] xfer_addr_o,
    input logic [16:0] xfer_len_o,
    input logic        xfer_ack_i
);
    p_one_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dfetch_req_o && xfer_req_o));

    p_fetch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dfetch_req_o && !dfetch_ack_i && !abort_i) |=>
        (abort_i || (dfetch_req_o && $stable(dfetch_addr_o))));

    p_xfer_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && !xfer_ack_i && !abort_i) |=>
        (abort_i || (xfer_req_o && $stable(xfer_addr_o) && $stable(xfer_len_o))));

    p_fetch_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dfetch_req_o && dfetch_ack_i) |=> !dfetch_req_o);

    p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_o && !dfetch_req_o && !xfer_req_o));

    p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> (xfer_len_o != 17'd0 && xfer_len_o <= 17'h10000));

    p_fetch_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dfetch_req_o |-> (dfetch_addr_o[1:0] == 2'b00));

    p_end_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || exhausted_o) |=> (!done_o && !exhausted_o && !busy_o));

    p_end_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && exhausted_o));
endmodule

bind sg_dma_walker sgw_checker u_sgw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .abort_i       (abort_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .exhausted_o   (exhausted_o),
    .dfetch_req_o  (dfetch_req_o),
    .dfetch_addr_o (dfetch_addr_o),
    .dfetch_ack_i  (dfetch_ack_i),
    .xfer_req_o    (xfer_req_o),
    .xfer_addr_o   (xfer_addr_o),
    .xfer_len_o    (xfer_len_o),
    .xfer_ack_i    (xfer_ack_i)
);

// File: tb/sg_dma_walker_bench.sv
`timescale 1ns/1ps
module sg_dma_walker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        abort_i = 1'b0;
    logic        dir_wr_i = 1'b0;
    logic [31:0] tbl_base_i = '0;
    logic [23:0] dev_bytes_i = '0;
    logic        busy_o, done_o, exhausted_o;
    logic        dfetch_req_o;
    logic [31:0] dfetch_addr_o;
    logic        dfetch_ack_i = 1'b0;
    logic [63:0] dfetch_data_i = '0;
    logic        xfer_req_o, xfer_we_o;
    logic [31:0] xfer_addr_o;
    logic [16:0] xfer_len_o;
    logic        xfer_ack_i = 1'b0;

    always #4 clk = ~clk;

    sg_dma_walker u_sg_dma_walker (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
        .dir_wr_i(dir_wr_i), .tbl_base_i(tbl_base_i), .dev_bytes_i(dev_bytes_i),
        .busy_o(busy_o), .done_o(done_o), .exhausted_o(exhausted_o),
        .dfetch_req_o(dfetch_req_o), .dfetch_addr_o(dfetch_addr_o),
        .dfetch_ack_i(dfetch_ack_i), .dfetch_data_i(dfetch_data_i),
        .xfer_req_o(xfer_req_o), .xfer_we_o(xfer_we_o), .xfer_addr_o(xfer_addr_o),
        .xfer_len_o(xfer_len_o), .xfer_ack_i(xfer_ack_i)
    );

    int total = 0;
    int bad = 0;

    // responder bookkeeping
    int          kind = 0;
    logic [31:0] base_al = '0;
    bit          hold = 1'b0;
    int          fetch_cnt, chunk_cnt, done_cnt, exh_cnt, hold_err, xwait;
    longint      byte_sum;
    logic [31:0] f_addr [4];
    logic [31:0] c_addr [4];
    logic [16:0] c_len  [4];
    logic        c_we   [4];
    logic        pf_req, pf_ack, px_req, px_ack;
    logic [31:0] pf_addr, px_addr;
    logic [16:0] px_len;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] desc_word(input int k, input int idx);
        logic [31:0] a, f;
        case (k)
            0: begin a = 32'(idx + 1) << 16;          f = 32'h100 | ((idx == 3) ? 32'h8000_0000 : 32'h0); end
            1: begin a = 32'h10_0000 * 32'(idx + 1);  f = (idx == 1) ? 32'h8000_0000 : 32'h0; end
            2: begin a = 32'h4000_0000 + 32'(idx) * 32'h100; f = 32'h0000_0101; end
            default: begin a = 32'h5000; f = 32'h8000_0000; end
        endcase
        return {f, a};
    endfunction

    task automatic clear_log();
        fetch_cnt = 0; chunk_cnt = 0; done_cnt = 0; exh_cnt = 0; byte_sum = 0;
        for (int i = 0; i < 4; i++) begin
            f_addr[i] = '0; c_addr[i] = '0; c_len[i] = '0; c_we[i] = 1'b0;
        end
    endtask

    // memory-side responder, works at the falling edge
    initial begin
        hold_err = 0; xwait = 0;
        pf_req = 0; pf_ack = 0; px_req = 0; px_ack = 0;
        pf_addr = '0; px_addr = '0; px_len = '0;
        clear_log();
        forever begin
            @(negedge clk);
            if (dfetch_req_o && pf_req && !pf_ack && dfetch_addr_o != pf_addr) hold_err++;
            if (xfer_req_o && px_req && !px_ack && (xfer_addr_o != px_addr || xfer_len_o != px_len)) hold_err++;
            if (dfetch_req_o && xfer_req_o) hold_err++;
            pf_req = dfetch_req_o; pf_addr = dfetch_addr_o;
            px_req = xfer_req_o;   px_addr = xfer_addr_o; px_len = xfer_len_o;
            if (dfetch_req_o && !dfetch_ack_i && !hold) begin
                dfetch_ack_i  = 1'b1;
                dfetch_data_i = desc_word(kind, int'((dfetch_addr_o - base_al) >> 3));
                if (fetch_cnt < 4) f_addr[fetch_cnt] = dfetch_addr_o;
                fetch_cnt++;
            end else begin
                dfetch_ack_i = 1'b0;
            end
            if (xfer_req_o && !xfer_ack_i && !hold) begin
                if (xwait >= 1) begin
                    xfer_ack_i = 1'b1;
                    xwait = 0;
                    if (chunk_cnt < 4) begin
                        c_addr[chunk_cnt] = xfer_addr_o;
                        c_len[chunk_cnt]  = xfer_len_o;
                        c_we[chunk_cnt]   = xfer_we_o;
                    end
                    chunk_cnt++;
                    byte_sum += longint'(xfer_len_o);
                end else begin
                    xwait++;
                end
            end else begin
                xfer_ack_i = 1'b0;
            end
            pf_ack = dfetch_ack_i; px_ack = xfer_ack_i;
            if (done_o) done_cnt++;
            if (exhausted_o) exh_cnt++;
        end
    end

    task automatic kick(input logic [31:0] base, input logic [23:0] dev, input int k, input logic dir);
        @(posedge clk); #1;
        clear_log();
        kind = k; base_al = {base[31:2], 2'b00};
        tbl_base_i = base; dev_bytes_i = dev; dir_wr_i = dir; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_end();
        for (int n = 0; n < 20000; n++) begin
            @(posedge clk);
            if (done_cnt + exh_cnt > 0) break;
        end
        repeat (3) @(posedge clk);
    endtask

    typedef struct packed {
        logic [23:0] dev;
        logic [1:0]  k;
        logic [9:0]  fetches;
        logic [9:0]  chunks;
        logic [23:0] bytes;
        logic        exh;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{24'h000300, 2'd0, 10'd3,   10'd3,   24'h000300, 1'b0},
        '{24'h000500, 2'd0, 10'd4,   10'd4,   24'h000400, 1'b1},
        '{24'h000180, 2'd0, 10'd2,   10'd2,   24'h000180, 1'b0},
        '{24'h018000, 2'd1, 10'd2,   10'd2,   24'h018000, 1'b0},
        '{24'h025800, 2'd2, 10'd512, 10'd512, 24'h020000, 1'b1},
        '{24'h000000, 2'd3, 10'd0,   10'd0,   24'h000000, 1'b0}
    };

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        // R1: reset state
        chk(!busy_o && !done_o && !exhausted_o, "R1 idle outputs",
            longint'({busy_o, done_o, exhausted_o}), 0);
        chk(!dfetch_req_o && !xfer_req_o, "R1 no request",
            longint'({dfetch_req_o, xfer_req_o}), 0);
        rst_n = 1'b1;

        // vector table
        for (int v = 0; v < 6; v++) begin
            kick(32'h0000_2000, VECS[v].dev, int'(VECS[v].k), 1'b0);
            wait_end();
            chk(fetch_cnt == int'(VECS[v].fetches), "R5/R7 fetch count", fetch_cnt, VECS[v].fetches);
            chk(chunk_cnt == int'(VECS[v].chunks), "R4 chunk count", chunk_cnt, VECS[v].chunks);
            chk(byte_sum == longint'(VECS[v].bytes), "R4 bytes moved", byte_sum, VECS[v].bytes);
            chk(exh_cnt == int'(VECS[v].exh) && done_cnt == int'(!VECS[v].exh),
                "R6/R8 end pulse", longint'({exh_cnt[3:0], done_cnt[3:0]}),
                longint'({3'b0, VECS[v].exh, 3'b0, !VECS[v].exh}));
        end

        // R2 / R4: unaligned base, write direction, chunk layout
        kick(32'h0000_2003, 24'h180, 0, 1'b1);
        wait_end();
        chk(f_addr[0] == 32'h2000, "R2 first fetch aligned", f_addr[0], 32'h2000);
        chk(f_addr[1] == 32'h2008, "R2 pointer step", f_addr[1], 32'h2008);
        chk(c_addr[0] == 32'h10000 && c_len[0] == 17'h100, "R4 chunk0",
            longint'({c_addr[0], 15'b0, c_len[0]}), longint'({32'h10000, 32'h100}));
        chk(c_addr[1] == 32'h20000 && c_len[1] == 17'h80, "R4 chunk1 min",
            longint'({c_addr[1], 15'b0, c_len[1]}), longint'({32'h20000, 32'h80}));
        chk(c_we[0] == 1'b1, "R4 direction", c_we[0], 1);
        chk(done_cnt == 1 && fetch_cnt == 2, "R5 no extra fetch", fetch_cnt, 2);

        // R3: odd count bit ignored, zero count means 64 KiB
        kick(32'h0000_3000, 24'h100, 2, 1'b0);
        wait_end();
        chk(c_len[0] == 17'h100 && chunk_cnt == 1, "R3 bit0 ignored", c_len[0], 17'h100);
        chk(c_addr[0] == 32'h4000_0000, "R3 region address", c_addr[0], 32'h4000_0000);
        kick(32'h0000_3000, 24'h18000, 1, 1'b0);
        wait_end();
        chk(c_len[0] == 17'h10000, "R3 zero means 65536", c_len[0], 17'h10000);
        chk(c_len[1] == 17'h8000 && c_addr[1] == 32'h20_0000, "R4 tail chunk", c_len[1], 17'h8000);

        // R8: zero device bytes
        kick(32'h0000_2000, 24'h0, 0, 1'b0);
        wait_end();
        chk(done_cnt == 1 && fetch_cnt == 0 && chunk_cnt == 0, "R8 zero count done",
            fetch_cnt + chunk_cnt, 0);

        // R10: abort with a fetch pending
        hold = 1'b1;
        kick(32'h0000_2000, 24'h300, 0, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(dfetch_req_o == 1'b1, "R10 fetch pending before abort", dfetch_req_o, 1);
        @(posedge clk); #1;
        abort_i = 1'b1;
        #1;
        chk(!dfetch_req_o && !xfer_req_o, "R10 requests dropped", dfetch_req_o, 0);
        @(posedge clk); #1;
        abort_i = 1'b0;
        hold = 1'b0;
        @(negedge clk);
        chk(!busy_o, "R10 idle after abort", busy_o, 0);
        repeat (5) @(posedge clk);
        chk(done_cnt == 0 && exh_cnt == 0 && fetch_cnt == 0, "R10 no end pulse",
            done_cnt + exh_cnt + fetch_cnt, 0);

        // R11: start while busy is ignored
        kick(32'h0000_2000, 24'h180, 0, 1'b0);
        @(posedge clk); #1;
        tbl_base_i = 32'h0000_6000; dev_bytes_i = 24'h500; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        wait_end();
        chk(byte_sum == 64'h180 && done_cnt == 1, "R11 restart ignored", byte_sum, 64'h180);
        chk(f_addr[0] == 32'h2000, "R11 base kept", f_addr[0], 32'h2000);

        // R9: request stability across all runs
        chk(hold_err == 0, "R9 single stable request", hold_err, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule